// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Slave

This block is a synthesizable model of a three-wire serial EEPROM target device. A host raises chip select, then shifts an instruction into the serial data input on rising shift-clock edges: a start bit, a two-bit opcode and an address. Depending on the instruction, data bits follow. The 16 Kbit array is organized either as 1024 words of 16 bits or as 2048 bytes, and the organization input selects which one. Read data comes back on the serial output, which has its own output-enable flag for a tri-state pad.

Programming instructions are blocked by a protection latch, which reset clears. While that latch is open, an instruction that writes or erases starts a self-timed programming interval. Its length in system clocks is a parameter. When the host drops and raises chip select during that interval, the serial output reports whether the device is busy or ready. All pins are sampled in the system clock domain through a configurable synchronizer, so shift-clock edges are detected rather than used as a clock.

Top module: `eep3w_slave`

## Requirements
- R1: After reset the protection latch is closed, every word of the array reads as all ones, and `dout_oe` is low.
- R2: After `cs` goes high, leading 0 bits are skipped and the first 1 bit sampled on a rising `sk` edge is the start bit. Next come a 2-bit opcode and then an address, all MSB first. The address is 10 bits when `org` = 1 (16-bit words) and 11 bits when `org` = 0 (bytes).
- R3: The opcode values are 10 for read, 01 for write and 11 for erase. Opcode 00 is a special command, chosen by the two most significant address bits: 11 opens the protection latch, 00 closes it, 10 erases all words and 01 writes all words. The other address bits are ignored.
- R4: For a read, on the rising `sk` edge that samples the last address bit, `dout` is driven 0 with `dout_oe` high. Each later rising edge presents the next data bit, MSB first. A read works whether the latch is open or closed.
- R5: While `cs` stays high, a read continues with the next address and no extra 0 bit. It wraps from the last address to address 0.
- R6: In byte mode, byte address bit 0 selects the half of word (address >> 1): 0 is bits 7:0 and 1 is bits 15:8.
- R7: With the latch closed, write, erase, erase-all and write-all leave the array unchanged and start no busy interval. Opening the latch enables them. Closing it blocks them again.
- R8: Erase sets the addressed word or byte to all ones. Write stores the shifted data directly, with no erase needed first.
- R9: Erase-all sets every word to all ones. Write-all stores its data in every word, and in byte mode it fills both halves of each word with the byte.
- R10: A programming instruction stays busy for `PROG_CYCLES` clocks. The interval starts after the last data bit for write and write-all, and after the last address bit for erase and erase-all.
- R11: If `cs` rises while busy, the device drives `dout` = 0 while busy and 1 once ready, holding that until `cs` falls. If `cs` rises after the interval has ended, no status is driven.
- R12: An instruction shifted after a `cs` rise that happened while busy is ignored.
- R13: `dout_oe` is low while `cs` is low and while an instruction is being shifted. Dropping `cs` before an instruction is complete discards it with no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset, stands in for power-up |
| cs | input | 1 | Chip select, active high |
| sk | input | 1 | Serial shift clock, sampled |
| di | input | 1 | Serial data input |
| org | input | 1 | Organization: 1 = 16-bit words, 0 = bytes |
| dout | output | 1 | Serial data or ready/busy status |
| dout_oe | output | 1 | Output enable for `dout` |

## Verification
The assertions assume that each `sk` phase lasts longer than the synchronizer depth plus one clock, so that every rising edge is seen exactly once. They also assume that `di` is settled before the `sk` rise that samples it, and that `org` does not change while `cs` is high. The bench drives every pin on the falling system-clock edge and holds each `sk` phase for four clocks. It changes `org` only while `cs` is low, so every sampled bit is well defined after the two synchronizer stages.

// File: rtl/eep3w_pkg.sv
package eep3w_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_START,
      ST_CMD,
      ST_DATA,
      ST_READ,
      ST_STAT,
      ST_DONE
   } eep_state_t;

   localparam logic [1:0] OPC_READ  = 2'b10;
   localparam logic [1:0] OPC_WRITE = 2'b01;
   localparam logic [1:0] OPC_ERASE = 2'b11;
   localparam logic [1:0] OPC_SPEC  = 2'b00;

   localparam logic [1:0] SPC_OPEN  = 2'b11;
   localparam logic [1:0] SPC_CLRALL = 2'b10;
   localparam logic [1:0] SPC_FILL  = 2'b01;
   localparam logic [1:0] SPC_CLOSE = 2'b00;

endpackage

// File: rtl/eep3w_in_sync.sv
module eep3w_in_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cs,
   input  logic sk,
   input  logic di,
   input  logic org,
   output logic cs_q,
   output logic di_q,
   output logic org_q,
   output logic sk_rise
);

   logic [3:0] raw;
   logic [3:0] synced;
   logic       sk_prev;

   assign raw = {cs, sk, di, org};

   initial begin
      assert (STAGES >= 0 && STAGES <= 4)
         else $error("eep3w_in_sync: STAGES must be 0..4");
   end

   generate
      if (STAGES == 0) begin : g_direct
         assign synced = raw;
      end else begin : g_chain
         logic [3:0] st [STAGES];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < STAGES; i++) st[i] <= '0;
            end else begin
               st[0] <= raw;
               for (int i = 1; i < STAGES; i++) st[i] <= st[i-1];
            end
         end
         assign synced = st[STAGES-1];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sk_prev <= 1'b0;
      else        sk_prev <= synced[2];
   end

   assign cs_q    = synced[3];
   assign di_q    = synced[1];
   assign org_q   = synced[0];
   assign sk_rise = synced[2] & ~sk_prev;

endmodule

// File: rtl/eep3w_prog_timer.sv
module eep3w_prog_timer #(
   parameter int CYCLES = 200
) (
   input  logic clk,
   input  logic rst_n,
   input  logic go,
   output logic busy
);

   localparam int CNT_W = $clog2(CYCLES + 1);

   logic [CNT_W-1:0] remain;

   initial begin
      assert (CYCLES >= 2)
         else $error("eep3w_prog_timer: CYCLES must be at least 2");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              remain <= '0;
      else if (go)             remain <= CNT_W'(CYCLES);
      else if (remain != '0)   remain <= remain - 1'b1;
   end

   assign busy = (remain != '0);

   // R10: a busy interval is only ever opened by a start pulse
   a_r10_busy_needs_go: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(go));

endmodule

// File: rtl/eep3w_array.sv
module eep3w_array #(
   parameter int WORD_AW = 10,
   parameter int WORD_W  = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               x16,
   input  logic               wr_go,
   input  logic               wr_all,
   input  logic [WORD_AW:0]   waddr,
   input  logic [WORD_W-1:0]  wdata,
   input  logic [WORD_AW:0]   raddr,
   output logic [WORD_W-1:0]  rdata
);

   localparam int DEPTH  = 1 << WORD_AW;
   localparam int BYTE_W = WORD_W / 2;

   logic [WORD_W-1:0]  mem [DEPTH];
   logic [WORD_AW-1:0] wword;
   logic [WORD_AW-1:0] rword;
   logic [WORD_W-1:0]  fill;

   initial begin
      assert (WORD_W >= 4 && (WORD_W % 2) == 0)
         else $error("eep3w_array: WORD_W must be even and at least 4");
      assert (WORD_AW >= 2 && WORD_AW <= 12)
         else $error("eep3w_array: WORD_AW out of range");
   end

   assign wword = x16 ? waddr[WORD_AW-1:0] : waddr[WORD_AW:1];
   assign rword = x16 ? raddr[WORD_AW-1:0] : raddr[WORD_AW:1];
   assign fill  = x16 ? wdata : {2{wdata[BYTE_W-1:0]}};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) mem[i] <= '1;
      end else if (wr_go) begin
         if (wr_all) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= fill;
         end else if (x16) begin
            mem[wword] <= wdata;
         end else if (waddr[0]) begin
            mem[wword][WORD_W-1 -: BYTE_W] <= wdata[BYTE_W-1:0];
         end else begin
            mem[wword][BYTE_W-1:0] <= wdata[BYTE_W-1:0];
         end
      end
   end

   always_comb begin
      if (x16)           rdata = mem[rword];
      else if (raddr[0]) rdata = {{BYTE_W{1'b0}}, mem[rword][WORD_W-1 -: BYTE_W]};
      else               rdata = {{BYTE_W{1'b0}}, mem[rword][BYTE_W-1:0]};
   end

endmodule

// File: rtl/eep3w_slave.sv
module eep3w_slave
   import eep3w_pkg::*;
#(
   parameter int WORD_AW     = 10,
   parameter int WORD_W      = 16,
   parameter int PROG_CYCLES = 200,
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cs,
   input  logic sk,
   input  logic di,
   input  logic org,
   output logic dout,
   output logic dout_oe
);

   localparam int BYTE_W  = WORD_W / 2;
   localparam int BYTE_AW = WORD_AW + 1;
   localparam int CMD_W   = 2 + BYTE_AW;
   localparam int CNT_W   = $clog2(CMD_W + WORD_W + 1);
   localparam int BIT_W   = $clog2(WORD_W);

   logic cs_q, di_q, org_q, sk_rise;
   logic busy;

   eep_state_t         state;
   logic               x16;
   logic               wen;
   logic [CNT_W-1:0]   cnt;
   logic [CMD_W-1:0]   cmd_sr, cmd_nxt;
   logic [WORD_W-1:0]  dat_sr, dat_nxt;
   logic [BYTE_AW-1:0] rd_addr, op_addr, addr_f;
   logic [BIT_W-1:0]   bit_idx, dw_top;
   logic [WORD_W-1:0]  op_data, rdata;
   logic               op_all, go, dout_q;
   logic [1:0]         opc, spc;
   logic               cmd_last, dat_last;

   initial begin
      assert (PROG_CYCLES >= 2 && SYNC_STAGES >= 0)
         else $error("eep3w_slave: bad timing parameters");
   end

   eep3w_in_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .cs(cs), .sk(sk), .di(di), .org(org),
      .cs_q(cs_q), .di_q(di_q), .org_q(org_q), .sk_rise(sk_rise)
   );

   eep3w_prog_timer #(.CYCLES(PROG_CYCLES)) u_timer (
      .clk(clk), .rst_n(rst_n), .go(go), .busy(busy)
   );

   eep3w_array #(.WORD_AW(WORD_AW), .WORD_W(WORD_W)) u_array (
      .clk(clk), .rst_n(rst_n), .x16(x16),
      .wr_go(go), .wr_all(op_all), .waddr(op_addr), .wdata(op_data),
      .raddr(rd_addr), .rdata(rdata)
   );

   // instruction field decode on the incoming bit
   assign cmd_nxt  = {cmd_sr[CMD_W-2:0], di_q};
   assign dat_nxt  = {dat_sr[WORD_W-2:0], di_q};
   assign opc      = x16 ? cmd_nxt[CMD_W-2 -: 2] : cmd_nxt[CMD_W-1 -: 2];
   assign spc      = x16 ? cmd_nxt[WORD_AW-1 -: 2] : cmd_nxt[BYTE_AW-1 -: 2];
   assign addr_f   = x16 ? {1'b0, cmd_nxt[WORD_AW-1:0]} : cmd_nxt[BYTE_AW-1:0];
   assign cmd_last = (cnt == (x16 ? CNT_W'(CMD_W-2) : CNT_W'(CMD_W-1)));
   assign dat_last = (cnt == (x16 ? CNT_W'(WORD_W-1) : CNT_W'(BYTE_W-1)));
   assign dw_top   = x16 ? BIT_W'(WORD_W-1) : BIT_W'(BYTE_W-1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         x16     <= 1'b1;
         wen     <= 1'b0;
         cnt     <= '0;
         cmd_sr  <= '0;
         dat_sr  <= '0;
         rd_addr <= '0;
         op_addr <= '0;
         op_data <= '0;
         op_all  <= 1'b0;
         bit_idx <= '0;
         go      <= 1'b0;
         dout_q  <= 1'b0;
      end else begin
         go <= 1'b0;
         if (!cs_q) begin
            state <= ST_IDLE;
         end else begin
            case (state)
               ST_IDLE: state <= busy ? ST_STAT : ST_START;
               ST_START: if (sk_rise && di_q) begin
                  state <= ST_CMD;
                  cnt   <= '0;
                  x16   <= org_q;
               end
               ST_CMD: if (sk_rise) begin
                  cmd_sr <= cmd_nxt;
                  cnt    <= cnt + 1'b1;
                  if (cmd_last) begin
                     state <= ST_DONE;
                     case (opc)
                        OPC_READ: begin
                           dout_q  <= 1'b0;
                           rd_addr <= addr_f;
                           bit_idx <= dw_top;
                           state   <= ST_READ;
                        end
                        OPC_WRITE: begin
                           op_addr <= addr_f;
                           op_all  <= 1'b0;
                           cnt     <= '0;
                           state   <= ST_DATA;
                        end
                        OPC_ERASE: begin
                           op_addr <= addr_f;
                           op_all  <= 1'b0;
                           op_data <= '1;
                           go      <= wen;
                        end
                        default: begin
                           case (spc)
                              SPC_OPEN:  wen <= 1'b1;
                              SPC_CLOSE: wen <= 1'b0;
                              SPC_CLRALL: begin
                                 op_all  <= 1'b1;
                                 op_data <= '1;
                                 go      <= wen;
                              end
                              default: begin
                                 op_all <= 1'b1;
                                 cnt    <= '0;
                                 state  <= ST_DATA;
                              end
                           endcase
                        end
                     endcase
                  end
               end
               ST_DATA: if (sk_rise) begin
                  dat_sr <= dat_nxt;
                  cnt    <= cnt + 1'b1;
                  if (dat_last) begin
                     op_data <= dat_nxt;
                     go      <= wen;
                     state   <= ST_DONE;
                  end
               end
               ST_READ: if (sk_rise) begin
                  dout_q <= rdata[bit_idx];
                  if (bit_idx == '0) begin
                     bit_idx <= dw_top;
                     rd_addr <= rd_addr + 1'b1;
                  end else begin
                     bit_idx <= bit_idx - 1'b1;
                  end
               end
               default: ;
            endcase
         end
      end
   end

   assign dout    = (state == ST_STAT) ? ~busy : dout_q;
   assign dout_oe = (state == ST_READ) || (state == ST_STAT);

   // R13: the pad is released one clock after chip select drops
   a_r13_oe_off_after_cs: assert property (@(posedge clk) disable iff (!rst_n)
      !cs_q |=> !dout_oe);

   // R4: the first driven read bit is the zero placeholder
   a_r4_dummy_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_READ && $past(state) == ST_CMD) |-> (dout == 1'b0));

   // R12: no programming start is issued while an interval is running
   a_r12_no_go_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
      go |-> !busy);

   // R7: the protection latch moves only on a decoded instruction
   a_r7_latch_from_decode: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(wen) |-> ($past(state) == ST_CMD));

endmodule

// File: tb/eep3w_slave_bench.sv
module eep3w_slave_bench;

   localparam int PROG = 200;

   logic clk = 1'b0;
   logic rst_n, cs, sk, di, org;
   logic dout, dout_oe;
   int   checks = 0;
   int   errors = 0;

   always #2 clk = ~clk;

   eep3w_slave #(.WORD_AW(10), .WORD_W(16), .PROG_CYCLES(PROG), .SYNC_STAGES(2)) u_eep3w_slave (
      .clk(clk), .rst_n(rst_n), .cs(cs), .sk(sk), .di(di), .org(org),
      .dout(dout), .dout_oe(dout_oe)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic clk_wait(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic sk_bit(input logic b);
      di = b; clk_wait(4); sk = 1'b1; clk_wait(4); sk = 1'b0;
   endtask

   task automatic cs_up(input logic o);
      org = o; cs = 1'b1; clk_wait(4);
   endtask

   task automatic cs_down();
      cs = 1'b0; di = 1'b0; clk_wait(6);
   endtask

   task automatic send_hdr(input logic o, input logic [1:0] op, input logic [10:0] a);
      sk_bit(1'b1); sk_bit(op[1]); sk_bit(op[0]);
      for (int i = (o ? 9 : 10); i >= 0; i--) sk_bit(a[i]);
   endtask

   task automatic send_data(input logic o, input logic [15:0] d);
      for (int i = (o ? 15 : 7); i >= 0; i--) sk_bit(d[i]);
   endtask

   task automatic prog(input logic o, input logic [1:0] op, input logic [10:0] a,
                       input logic [15:0] d, input logic with_data);
      cs_up(o); send_hdr(o, op, a);
      if (with_data) send_data(o, d);
      cs_down(); clk_wait(PROG + 20);
   endtask

   function automatic logic [10:0] spc_addr(input logic o, input logic [1:0] code);
      return o ? {1'b0, code, 8'b0} : {code, 9'b0};
   endfunction

   task automatic read_first(input logic o, input logic [10:0] a, input string req);
      cs_up(o); send_hdr(o, 2'b10, a);
      chk({req, " dummy bit"}, {30'b0, dout_oe, dout}, 32'h2);
   endtask

   task automatic get_word(input logic o, output logic [15:0] v);
      v = '0;
      for (int i = 0; i < (o ? 16 : 8); i++) begin
         sk_bit(1'b0);
         v = {v[14:0], dout};
      end
   endtask

   task automatic read_chk(input logic o, input logic [10:0] a, input logic [15:0] exp, input string req);
      logic [15:0] v;
      read_first(o, a, req); get_word(o, v); cs_down();
      chk(req, {16'b0, v}, {16'b0, exp});
   endtask

   task automatic t_reset();
      chk("R1 oe after reset", {31'b0, dout_oe}, 32'h0);
      read_chk(1'b1, 11'd5, 16'hFFFF, "R1 blank word");
      // R2: leading zeros before the start bit are skipped
      cs_up(1'b1); sk_bit(1'b0); sk_bit(1'b0);
      send_hdr(1'b1, 2'b10, 11'd1023);
      chk("R2 dummy after leading zeros", {30'b0, dout_oe, dout}, 32'h2);
      begin
         logic [15:0] v;
         get_word(1'b1, v); chk("R2 read after leading zeros", {16'b0, v}, 32'hFFFF);
      end
      cs_down();
   endtask

   task automatic t_protect();
      prog(1'b1, 2'b01, 11'd3, 16'h1234, 1'b1);
      read_chk(1'b1, 11'd3, 16'hFFFF, "R7 write blocked when closed");
   endtask

   task automatic t_write_erase();
      prog(1'b1, 2'b00, spc_addr(1'b1, 2'b11), 16'h0, 1'b0);
      prog(1'b1, 2'b01, 11'd3, 16'hA5C3, 1'b1);
      read_chk(1'b1, 11'd3, 16'hA5C3, "R3 R8 write word");
      prog(1'b1, 2'b01, 11'd3, 16'h0F0F, 1'b1);
      read_chk(1'b1, 11'd3, 16'h0F0F, "R8 overwrite without erase");
      prog(1'b1, 2'b11, 11'd3, 16'h0, 1'b0);
      read_chk(1'b1, 11'd3, 16'hFFFF, "R8 erase word");
   endtask

   task automatic t_sequential();
      logic [15:0] v;
      prog(1'b1, 2'b01, 11'd10, 16'h1111, 1'b1);
      prog(1'b1, 2'b01, 11'd11, 16'h2222, 1'b1);
      read_first(1'b1, 11'd10, "R5 seq");
      get_word(1'b1, v); chk("R5 seq word0", {16'b0, v}, 32'h1111);
      get_word(1'b1, v); chk("R5 seq word1 no dummy", {16'b0, v}, 32'h2222);
      get_word(1'b1, v); chk("R5 seq word2", {16'b0, v}, 32'hFFFF);
      cs_down();
      prog(1'b1, 2'b01, 11'd0, 16'h0B0B, 1'b1);
      prog(1'b1, 2'b01, 11'd1023, 16'hABCD, 1'b1);
      read_first(1'b1, 11'd1023, "R5 wrap");
      get_word(1'b1, v); chk("R5 wrap last", {16'b0, v}, 32'hABCD);
      get_word(1'b1, v); chk("R5 wrap to zero", {16'b0, v}, 32'h0B0B);
      cs_down();
   endtask

   task automatic t_bytes();
      logic [15:0] v;
      prog(1'b0, 2'b01, 11'd41, 16'h005A, 1'b1);
      prog(1'b0, 2'b01, 11'd40, 16'h003C, 1'b1);
      read_chk(1'b1, 11'd20, 16'h5A3C, "R6 byte lanes");
      read_first(1'b0, 11'd41, "R6 byte read");
      get_word(1'b0, v); chk("R6 byte 41", {16'b0, v}, 32'h005A);
      get_word(1'b0, v); chk("R5 R6 byte 42 sequential", {16'b0, v}, 32'h00FF);
      cs_down();
   endtask

   task automatic t_status();
      cs_up(1'b1); send_hdr(1'b1, 2'b01, 11'd50); send_data(1'b1, 16'hCAFE);
      cs_down(); cs_up(1'b1);
      chk("R11 busy status", {30'b0, dout_oe, dout}, 32'h2);
      clk_wait(PROG - 40);
      chk("R10 still busy near end", {30'b0, dout_oe, dout}, 32'h2);
      clk_wait(40);
      chk("R10 R11 ready status", {30'b0, dout_oe, dout}, 32'h3);
      cs_down();
      cs_up(1'b1); send_hdr(1'b1, 2'b01, 11'd51); send_data(1'b1, 16'hBEEF);
      cs_down(); clk_wait(PROG + 20); cs_up(1'b1);
      chk("R11 no status after interval", {31'b0, dout_oe}, 32'h0);
      cs_down();
      read_chk(1'b1, 11'd50, 16'hCAFE, "R11 word 50");
      read_chk(1'b1, 11'd51, 16'hBEEF, "R11 word 51");
   endtask

   task automatic t_busy_ignore();
      cs_up(1'b1); send_hdr(1'b1, 2'b01, 11'd60); send_data(1'b1, 16'h1357);
      cs_down(); cs_up(1'b1);
      send_hdr(1'b1, 2'b01, 11'd60); send_data(1'b1, 16'h2468);
      cs_down(); clk_wait(PROG + 20);
      read_chk(1'b1, 11'd60, 16'h1357, "R12 instruction while busy ignored");
   endtask

   task automatic t_abort();
      cs_up(1'b1); sk_bit(1'b1); sk_bit(1'b0); sk_bit(1'b1); sk_bit(1'b0);
      chk("R13 oe low while shifting", {31'b0, dout_oe}, 32'h0);
      cs_down();
      cs_up(1'b1); send_hdr(1'b1, 2'b01, 11'd60);
      for (int i = 15; i >= 1; i--) sk_bit(1'b0);
      cs_down(); clk_wait(PROG + 20);
      read_chk(1'b1, 11'd60, 16'h1357, "R13 partial write discarded");
      read_first(1'b1, 11'd60, "R13 read");
      sk_bit(1'b0);
      cs = 1'b0; clk_wait(6);
      chk("R13 oe low after cs drop", {31'b0, dout_oe}, 32'h0);
   endtask

   task automatic t_bulk();
      prog(1'b1, 2'b00, spc_addr(1'b1, 2'b01), 16'h7E81, 1'b1);
      read_chk(1'b1, 11'd0, 16'h7E81, "R9 fill word 0");
      read_chk(1'b1, 11'd1023, 16'h7E81, "R9 fill word 1023");
      prog(1'b0, 2'b00, spc_addr(1'b0, 2'b01), 16'h0096, 1'b1);
      read_chk(1'b1, 11'd7, 16'h9696, "R9 byte fill");
      prog(1'b1, 2'b00, spc_addr(1'b1, 2'b10), 16'h0, 1'b0);
      read_chk(1'b1, 11'd500, 16'hFFFF, "R9 erase all");
   endtask

   task automatic t_close();
      prog(1'b1, 2'b00, spc_addr(1'b1, 2'b00), 16'h0, 1'b0);
      prog(1'b1, 2'b01, 11'd5, 16'h0000, 1'b1);
      read_chk(1'b1, 11'd5, 16'hFFFF, "R7 write blocked after close");
   endtask

   initial begin
      rst_n = 1'b0; cs = 1'b0; sk = 1'b0; di = 1'b0; org = 1'b1;
      clk_wait(5); rst_n = 1'b1; clk_wait(3);
      t_reset();
      t_protect();
      t_write_erase();
      t_sequential();
      t_bytes();
      t_status();
      t_busy_ignore();
      t_abort();
      t_bulk();
      t_close();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog actual=running expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule